// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block steps a single-rank SDRAM with four banks, a 32-bit data bus and an 11-bit multiplexed address bus through its whole working life. After reset it runs a fixed number of auto-refresh commands, programs the mode register with a built-in default, and then serves one host access at a time. The host presents bank, row, column, direction, byte mask and write data together and holds them until the sequencer pulses completion. A host request flagged as a mode set reprograms the mode register from the low 11 bits of the write data instead of touching memory.

Each read or write opens its row, issues the column command with auto-precharge off, waits out the row-active time, and closes every bank with a precharge before the sequencer returns to idle. A periodic refresh timer raises a pending flag. The flag is served only from idle, and it wins over a host request that arrives in the same cycle. The state register uses a fixed 4-bit encoding of sixteen states.

Top module: `sdram_seq_top`

## Requirements
- R1: After reset the pins show NOP for one cycle. Then, PWR_REFS times: an AUTO REFRESH command, REF_DLY NOP cycles, and one further NOP. Then a LOAD MODE with sdBa=0 and sdAddr=0x020 (CAS latency code 010 in bits 6:4, sequential type in bit 3 = 0, burst length code 000 in bits 2:0). reqDone stays low throughout.
- R2: The commands on {sdCsN,sdRasN,sdCasN,sdWeN} are encoded as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. When no command is issued, sdBa and sdAddr are 0 and sdDqm is all ones.
- R3: An accepted access issues ACTIVE with the request bank and row in the cycle after the accepting idle cycle. One NOP follows. Then READ or WRITE is issued with the same bank and with the column zero-extended on sdAddr, so that bit 10 is 0.
- R4: For a read, sdDqm carries reqMask (1 = lane masked) in the READ cycle and in the two NOP cycles that follow. rdData takes the value on sdRdata during the third cycle after READ, and it is visible from the next cycle on.
- R5: For a write, sdDqOe is high and sdWdata carries the write data only in the WRITE command cycle, and sdDqm carries reqMask in that cycle. One NOP follows.
- R6: After the read-data cycle, or after the NOP that follows a write, come two NOPs and then PRECHARGE with sdAddr bit 10 = 1 (all banks). One NOP follows in which reqDone is high for exactly one cycle. The sequencer is idle in the next cycle.
- R7: Once initDone is high, a refresh becomes pending every REF_INTERVAL cycles. It is served from idle as AUTO REFRESH followed by REF_DLY NOPs, and the sequencer then returns to idle.
- R8: If a refresh is pending in an idle cycle, the refresh is issued even when a host request is present in that cycle. The host request is accepted at a later idle cycle.
- R9: A request with reqModeSet high issues LOAD MODE with sdAddr = reqWdata[10:0] in the cycle after acceptance. reqDone is high in that same cycle, and no ACTIVE is issued.
- R10: initDone is low until the cycle after the power-up LOAD MODE and high from then on. A request held during initialization is not acted on before initDone is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present; held until reqDone |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqModeSet | input | 1 | Request programs the mode register |
| reqBank | input | 2 | Bank of the access |
| reqRow | input | 11 | Row of the access |
| reqCol | input | 8 | Column of the access |
| reqMask | input | 4 | Byte-lane mask, 1 = lane masked |
| reqWdata | input | 32 | Write data, or mode value in bits 10:0 |
| reqDone | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Last captured read word |
| initDone | output | 1 | Power-up sequence complete |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank address |
| sdAddr | output | 11 | Multiplexed address |
| sdDqm | output | 4 | Data mask lanes |
| sdWdata | output | 32 | Data toward the SDRAM |
| sdDqOe | output | 1 | Drive enable for sdWdata |
| sdRdata | input | 32 | Data from the SDRAM |

## Verification
The assertions assume that the host keeps every request field steady from the cycle it raises reqValid until the cycle it sees reqDone, and that it lowers reqValid in that reqDone cycle. They also assume that sdRdata is stable around the capturing edge. The stimulus drives request fields only at the falling edge and changes them only while reqValid is low. It releases reqValid at the falling edge where reqDone is seen. The refresh interval is kept short and the request gaps are varied, so that pending refreshes collide with fresh requests many times during the run.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    ST_TRP     = 4'b0000,
    ST_IDLE    = 4'b0001,
    ST_RASDLY  = 4'b0010,
    ST_SETRAS  = 4'b0011,
    ST_WRITE   = 4'b0100,
    ST_CL2     = 4'b0101,
    ST_SETCAS  = 4'b0110,
    ST_CL1     = 4'b0111,
    ST_TRAS1   = 4'b1000,
    ST_TRAS2   = 4'b1001,
    ST_PWRUP   = 4'b1010,
    ST_MODE    = 4'b1011,
    ST_READ    = 4'b1100,
    ST_AREF    = 4'b1101,
    ST_PRE     = 4'b1110,
    ST_AREFDLY = 4'b1111
  } seqState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic accept;
    logic acceptMode;
    logic doActive;
    logic doRead;
    logic doWrite;
    logic doPre;
    logic doRefresh;
    logic doLoadMode;
    logic maskOn;
    logic driveData;
    logic capture;
    logic done;
  } seqStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_READ  = 4'b0101;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_LMR   = 4'b0000;

endpackage

// File: rtl/sdram_ref_timer.sv
`timescale 1ns/1ps
module sdram_ref_timer #(
  parameter int REF_INTERVAL = 750
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic takeRefresh,
  output logic refPending
);
  localparam int CNT_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(REF_INTERVAL - 1);

  logic [CNT_W-1:0] cntQ;
  logic             pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= RELOAD;
      pendQ <= 1'b0;
    end else begin
      if (takeRefresh) pendQ <= 1'b0;
      if (enable) begin
        if (cntQ == '0) begin
          cntQ  <= RELOAD;
          pendQ <= 1'b1;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  assign refPending = pendQ;

  // a refresh is only taken while one is pending
  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    takeRefresh |-> refPending); // R7

endmodule

// File: rtl/sdram_seq_ctrl.sv
`timescale 1ns/1ps
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int PWR_REFS = 3,
  parameter int REF_DLY  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqModeSet,
  input  logic       refPending,
  output logic       takeRefresh,
  output logic       initDone,
  output seqStrobe_t strb
);
  localparam int RC_W  = $clog2(PWR_REFS + 2);
  localparam int DLY_W = $clog2(REF_DLY + 1) > 0 ? $clog2(REF_DLY + 1) : 1;

  seqState_e        stateQ, stateD;
  logic [RC_W-1:0]  refsQ;
  logic [DLY_W-1:0] dlyQ;
  logic             wrQ;
  logic             initQ;

  wire idleFree = (stateQ == ST_IDLE) && !refPending && reqValid;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_PWRUP:   stateD = (refsQ < RC_W'(PWR_REFS)) ? ST_AREF : ST_MODE;
      ST_AREF:    stateD = ST_AREFDLY;
      ST_AREFDLY: if (dlyQ == DLY_W'(REF_DLY - 1))
                    stateD = initQ ? ST_IDLE : ST_PWRUP;
      ST_MODE:    stateD = ST_IDLE;
      ST_IDLE: begin
        if (refPending)               stateD = ST_AREF;
        else if (reqValid && reqModeSet) stateD = ST_MODE;
        else if (reqValid)            stateD = ST_SETRAS;
      end
      ST_SETRAS:  stateD = ST_RASDLY;
      ST_RASDLY:  stateD = ST_SETCAS;
      ST_SETCAS:  stateD = wrQ ? ST_WRITE : ST_CL1;
      ST_CL1:     stateD = ST_CL2;
      ST_CL2:     stateD = ST_READ;
      ST_READ:    stateD = ST_TRAS1;
      ST_WRITE:   stateD = ST_TRAS1;
      ST_TRAS1:   stateD = ST_TRAS2;
      ST_TRAS2:   stateD = ST_PRE;
      ST_PRE:     stateD = ST_TRP;
      ST_TRP:     stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_PWRUP;
      refsQ  <= '0;
      dlyQ   <= '0;
      wrQ    <= 1'b0;
      initQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_AREF) begin
        dlyQ <= '0;
        if (!initQ) refsQ <= refsQ + 1'b1;
      end else if (stateQ == ST_AREFDLY) begin
        dlyQ <= dlyQ + 1'b1;
      end
      if (idleFree && !reqModeSet) wrQ <= reqWrite;
      if (stateQ == ST_MODE) initQ <= 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.accept     = idleFree && !reqModeSet;
    strb.acceptMode = idleFree && reqModeSet;
    strb.doActive   = (stateQ == ST_SETRAS);
    strb.doRead     = (stateQ == ST_SETCAS) && !wrQ;
    strb.doWrite    = (stateQ == ST_SETCAS) && wrQ;
    strb.doPre      = (stateQ == ST_PRE);
    strb.doRefresh  = (stateQ == ST_AREF);
    strb.doLoadMode = (stateQ == ST_MODE);
    strb.maskOn     = (stateQ == ST_SETCAS) || (stateQ == ST_CL1) || (stateQ == ST_CL2);
    strb.driveData  = (stateQ == ST_SETCAS) && wrQ;
    strb.capture    = (stateQ == ST_READ);
    strb.done       = (stateQ == ST_TRP) || ((stateQ == ST_MODE) && initQ);
  end

  assign takeRefresh = (stateQ == ST_IDLE) && refPending;
  assign initDone    = initQ;

  AST_REF_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && refPending) |=> (stateQ == ST_AREF)); // R8

  AST_PRE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PRE) |-> ($past(stateQ, 3) == ST_READ || $past(stateQ, 3) == ST_WRITE)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done); // R6

  AST_NO_ACCESS_PREINIT: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (stateQ != ST_SETRAS && stateQ != ST_IDLE)); // R10

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doActive, strb.doRead, strb.doWrite, strb.doPre,
              strb.doRefresh, strb.doLoadMode})); // R2

endmodule

// File: rtl/sdram_seq_data.sv
`timescale 1ns/1ps
module sdram_seq_data
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] MODE_DEFAULT = 11'h020
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strb,
  input  logic [BANK_W-1:0]     reqBank,
  input  logic [ADDR_W-1:0]     reqRow,
  input  logic [COL_W-1:0]      reqCol,
  input  logic [DATA_W/8-1:0]   reqMask,
  input  logic [DATA_W-1:0]     reqWdata,
  output logic [3:0]            cmdVec,
  output logic [BANK_W-1:0]     sdBa,
  output logic [ADDR_W-1:0]     sdAddr,
  output logic [DATA_W/8-1:0]   sdDqm,
  output logic [DATA_W-1:0]     sdWdata,
  output logic                  sdDqOe,
  input  logic [DATA_W-1:0]     sdRdata,
  output logic [DATA_W-1:0]     rdData
);
  localparam int LANES  = DATA_W / 8;
  localparam int AP_BIT = 10;

  logic [BANK_W-1:0] bankQ;
  logic [ADDR_W-1:0] rowQ;
  logic [COL_W-1:0]  colQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] wdataQ;
  logic [ADDR_W-1:0] modeQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ  <= '0;
      rowQ   <= '0;
      colQ   <= '0;
      maskQ  <= '0;
      wdataQ <= '0;
      modeQ  <= MODE_DEFAULT;
      rdQ    <= '0;
    end else begin
      if (strb.accept) begin
        bankQ  <= reqBank;
        rowQ   <= reqRow;
        colQ   <= reqCol;
        maskQ  <= reqMask;
        wdataQ <= reqWdata;
      end
      if (strb.acceptMode) modeQ <= reqWdata[ADDR_W-1:0];
      if (strb.capture)    rdQ   <= sdRdata;
    end
  end

  always_comb begin
    if (strb.doActive)        cmdVec = CMD_ACT;
    else if (strb.doRead)     cmdVec = CMD_READ;
    else if (strb.doWrite)    cmdVec = CMD_WRITE;
    else if (strb.doPre)      cmdVec = CMD_PRE;
    else if (strb.doRefresh)  cmdVec = CMD_REF;
    else if (strb.doLoadMode) cmdVec = CMD_LMR;
    else                      cmdVec = CMD_NOP;
  end

  always_comb begin
    sdAddr = '0;
    sdBa   = '0;
    if (strb.doActive) begin
      sdAddr = rowQ;
      sdBa   = bankQ;
    end else if (strb.doRead || strb.doWrite) begin
      sdAddr = ADDR_W'(colQ);
      sdBa   = bankQ;
    end else if (strb.doPre) begin
      sdAddr[AP_BIT] = 1'b1;
    end else if (strb.doLoadMode) begin
      sdAddr = modeQ;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sdDqm[g] = strb.maskOn ? maskQ[g] : 1'b1;
  end

  assign sdWdata = wdataQ;
  assign sdDqOe  = strb.driveData;
  assign rdData  = rdQ;

  AST_CAS_AFTER_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdVec == CMD_READ || cmdVec == CMD_WRITE) |-> ($past(cmdVec, 2) == CMD_ACT)); // R3

  AST_DQ_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (cmdVec == CMD_WRITE)); // R5

  AST_CAPTURE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> ($past(cmdVec, 3) == CMD_READ)); // R4

  AST_ACT_AFTER_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdVec == CMD_ACT) |=> (cmdVec == CMD_NOP)); // R3

endmodule

// File: rtl/sdram_seq_top.sv
`timescale 1ns/1ps
module sdram_seq_top
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ADDR_W       = 11,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 32,
  parameter int PWR_REFS     = 3,
  parameter int REF_DLY      = 1,
  parameter int REF_INTERVAL = 750,
  parameter logic [2:0] CAS_LAT_CODE   = 3'b010,
  parameter logic       BURST_TYPE     = 1'b0,
  parameter logic [2:0] BURST_LEN_CODE = 3'b000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqModeSet,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [ADDR_W-1:0]   reqRow,
  input  logic [COL_W-1:0]    reqCol,
  input  logic [DATA_W/8-1:0] reqMask,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                reqDone,
  output logic [DATA_W-1:0]   rdData,
  output logic                initDone,
  output logic                sdCsN,
  output logic                sdRasN,
  output logic                sdCasN,
  output logic                sdWeN,
  output logic [BANK_W-1:0]   sdBa,
  output logic [ADDR_W-1:0]   sdAddr,
  output logic [DATA_W/8-1:0] sdDqm,
  output logic [DATA_W-1:0]   sdWdata,
  output logic                sdDqOe,
  input  logic [DATA_W-1:0]   sdRdata
);
  localparam logic [ADDR_W-1:0] MODE_DEFAULT =
    ADDR_W'({CAS_LAT_CODE, BURST_TYPE, BURST_LEN_CODE});

  seqStrobe_t strb;
  logic       refPending;
  logic       takeRefresh;
  logic [3:0] cmdVec;

  sdram_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) timer_i (
    .clk(clk), .rstN(rstN), .enable(initDone),
    .takeRefresh(takeRefresh), .refPending(refPending)
  );

  sdram_seq_ctrl #(.PWR_REFS(PWR_REFS), .REF_DLY(REF_DLY)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqModeSet(reqModeSet), .refPending(refPending),
    .takeRefresh(takeRefresh), .initDone(initDone), .strb(strb)
  );

  sdram_seq_data #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .MODE_DEFAULT(MODE_DEFAULT)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqMask(reqMask), .reqWdata(reqWdata),
    .cmdVec(cmdVec), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm),
    .sdWdata(sdWdata), .sdDqOe(sdDqOe), .sdRdata(sdRdata), .rdData(rdData)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdVec;
  assign reqDone = strb.done;

endmodule

// File: tb/sdram_seq_top_tb_top.sv
`timescale 1ns/1ps
module sdram_seq_top_tb_top;
  localparam int NREF = 3;
  localparam int DLY  = 2;
  localparam int RINT = 57;

  localparam logic [3:0] E_NOP = 4'b0111, E_ACT = 4'b0011, E_RD = 4'b0101,
                         E_WR = 4'b0100, E_PRE = 4'b0010, E_REF = 4'b0001,
                         E_LMR = 4'b0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqModeSet = 1'b0;
  logic [1:0]  reqBank = '0;
  logic [10:0] reqRow = '0;
  logic [7:0]  reqCol = '0;
  logic [3:0]  reqMask = '0;
  logic [31:0] reqWdata = '0;
  logic        reqDone, initDone, sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [31:0] rdData, sdWdata;
  logic [31:0] sdRdata = '0;
  logic [1:0]  sdBa;
  logic [10:0] sdAddr;
  logic [3:0]  sdDqm;

  sdram_seq_top #(.PWR_REFS(NREF), .REF_DLY(DLY), .REF_INTERVAL(RINT)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqModeSet(reqModeSet), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .reqMask(reqMask), .reqWdata(reqWdata),
    .reqDone(reqDone), .rdData(rdData), .initDone(initDone),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdWdata(sdWdata),
    .sdDqOe(sdDqOe), .sdRdata(sdRdata)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [10:0] addr;
    logic [3:0]  dqm;
    bit          oe;
    logic [31:0] wd;
    bit          done;
    bit          cap;
    bit          isMode;
    bit          isIdle;
    int          tag;
  } exp_t;

  exp_t        q[$];
  exp_t        cur;
  int          mCnt;
  bit          mPend, mInit, chkRd;
  logic [31:0] expRd;
  int          errs = 0, checks = 0, cyc = 0;
  bit          finished = 0;

  function automatic exp_t mk(logic [3:0] c, logic [1:0] b, logic [10:0] a,
                              logic [3:0] m, int t);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.dqm = m; e.oe = 0; e.wd = '0;
    e.done = 0; e.cap = 0; e.isMode = 0; e.isIdle = 0; e.tag = t;
    return e;
  endfunction

  function automatic exp_t idleE();
    exp_t e = mk(E_NOP, 2'd0, 11'd0, 4'hF, 2);
    e.isIdle = 1;
    return e;
  endfunction

  task automatic pushRefresh(int t);
    q.push_back(mk(E_REF, 2'd0, 11'd0, 4'hF, t));
    for (int i = 0; i < DLY; i++) q.push_back(mk(E_NOP, 2'd0, 11'd0, 4'hF, t));
  endtask

  // R3 R4 R5 R6: expected pin sequence for one access
  task automatic pushAccess();
    exp_t e;
    q.push_back(mk(E_ACT, reqBank, reqRow, 4'hF, 3));
    q.push_back(mk(E_NOP, 2'd0, 11'd0, 4'hF, 3));
    e = mk(reqWrite ? E_WR : E_RD, reqBank, {3'b000, reqCol}, reqMask, reqWrite ? 5 : 3);
    e.oe = reqWrite; e.wd = reqWdata;
    q.push_back(e);
    if (reqWrite) begin
      q.push_back(mk(E_NOP, 2'd0, 11'd0, 4'hF, 5));
    end else begin
      q.push_back(mk(E_NOP, 2'd0, 11'd0, reqMask, 4));
      q.push_back(mk(E_NOP, 2'd0, 11'd0, reqMask, 4));
      e = mk(E_NOP, 2'd0, 11'd0, 4'hF, 4);
      e.cap = 1;
      q.push_back(e);
    end
    q.push_back(mk(E_NOP, 2'd0, 11'd0, 4'hF, 6));
    q.push_back(mk(E_NOP, 2'd0, 11'd0, 4'hF, 6));
    q.push_back(mk(E_PRE, 2'd0, 11'h400, 4'hF, 6));
    e = mk(E_NOP, 2'd0, 11'd0, 4'hF, 6);
    e.done = 1;
    q.push_back(e);
  endtask

  // R1: power-up sequence model
  task automatic resetModel();
    exp_t e;
    q.delete();
    cur = mk(E_NOP, 2'd0, 11'd0, 4'hF, 1);
    for (int i = 0; i < NREF; i++) begin
      q.push_back(mk(E_REF, 2'd0, 11'd0, 4'hF, 1));
      for (int j = 0; j < DLY; j++) q.push_back(mk(E_NOP, 2'd0, 11'd0, 4'hF, 1));
      q.push_back(mk(E_NOP, 2'd0, 11'd0, 4'hF, 1));
    end
    e = mk(E_LMR, 2'd0, 11'h020, 4'hF, 1);
    e.isMode = 1;
    q.push_back(e);
    mCnt = RINT - 1; mPend = 0; mInit = 0; chkRd = 0;
  endtask

  initial resetModel();

  always @(posedge clk) begin
    if (!rstN) begin
      resetModel();
    end else begin
      bit take;
      exp_t e;
      take = cur.isIdle && mPend;
      if (cur.cap) begin expRd = sdRdata; chkRd = 1; end
      if (cur.isIdle) begin
        if (take) pushRefresh(reqValid ? 8 : 7);        // R7, R8 collision
        else if (reqValid && reqModeSet) begin          // R9
          e = mk(E_LMR, 2'd0, reqWdata[10:0], 4'hF, 9);
          e.done = 1; e.isMode = 1;
          q.push_back(e);
        end else if (reqValid) pushAccess();
      end
      if (take) mPend = 0;
      if (mInit) begin
        if (mCnt == 0) begin mCnt = RINT - 1; mPend = 1; end
        else mCnt = mCnt - 1;
      end
      if (cur.isMode) mInit = 1;                         // R10
      if (q.size() > 0) cur = q.pop_front();
      else cur = idleE();
    end
  end

  task automatic fail(int t, string what, logic [31:0] act, logic [31:0] exp);
    errs++;
    $display("FAIL R%0d %s actual=%0h expected=%0h (cycle %0d)", t, what, act, exp, cyc);
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rstN && !finished) begin
      checks++;
      // R2: command code on the four strobes
      if ({sdCsN, sdRasN, sdCasN, sdWeN} != cur.cmd)
        fail(cur.tag, "cmd", {28'd0, sdCsN, sdRasN, sdCasN, sdWeN}, {28'd0, cur.cmd});
      else if (sdBa != cur.ba) fail(cur.tag, "bank", {30'd0, sdBa}, {30'd0, cur.ba});
      else if (sdAddr != cur.addr) fail(cur.tag, "addr", {21'd0, sdAddr}, {21'd0, cur.addr});
      else if (sdDqm != cur.dqm) fail(cur.tag, "dqm", {28'd0, sdDqm}, {28'd0, cur.dqm});
      else if (sdDqOe != cur.oe) fail(5, "dqOe", {31'd0, sdDqOe}, {31'd0, cur.oe});
      else if (cur.oe && sdWdata != cur.wd) fail(5, "wdata", sdWdata, cur.wd);
      else if (reqDone != cur.done) fail(cur.tag, "done", {31'd0, reqDone}, {31'd0, cur.done});
      else if (initDone != mInit) fail(10, "initDone", {31'd0, initDone}, {31'd0, mInit});
      if (chkRd) begin
        checks++;
        chkRd = 0;
        if (rdData !== expRd) fail(4, "rdData", rdData, expRd);  // R4
      end
    end
    sdRdata = cyc * 32'h9E3779B1 + 32'd7;
  end

  task automatic hostReq(bit wr, bit ms, logic [1:0] b, logic [10:0] r,
                         logic [7:0] c, logic [3:0] m, logic [31:0] d);
    int waitc = 0;
    @(negedge clk);
    reqWrite = wr; reqModeSet = ms; reqBank = b; reqRow = r;
    reqCol = c; reqMask = m; reqWdata = d; reqValid = 1'b1;
    do begin
      @(negedge clk);
      waitc++;
    end while (!reqDone && waitc < 400);
    if (!reqDone) begin
      checks++;
      fail(6, "no reqDone", 32'd0, 32'd1);
    end
    reqValid = 1'b0;
  endtask

  task automatic finish();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fail(0, "watchdog", 32'd0, 32'd1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({sdCsN, sdRasN, sdCasN, sdWeN} != E_NOP || reqDone || initDone)
      fail(1, "reset state", {28'd0, sdCsN, sdRasN, sdCasN, sdWeN}, {28'd0, E_NOP});
    rstN = 1'b1;
    // R10: request raised during power-up is held until init completes
    hostReq(1, 0, 2'd1, 11'h155, 8'hAA, 4'h0, 32'hCAFE_0001);
    hostReq(0, 0, 2'd1, 11'h155, 8'hAA, 4'h0, 32'h0);
    hostReq(1, 0, 2'd3, 11'h7FF, 8'hFF, 4'hA, 32'h1234_5678);
    hostReq(0, 0, 2'd2, 11'h000, 8'h00, 4'h5, 32'h0);
    // R9: runtime mode set
    hostReq(1, 1, 2'd0, 11'h0, 8'h0, 4'h0, 32'hFFFF_F831);
    hostReq(0, 0, 2'd0, 11'h001, 8'h01, 4'hF, 32'h0);
    hostReq(1, 1, 2'd0, 11'h0, 8'h0, 4'h0, 32'h0000_0020);
    // R7, R8: varied gaps so refreshes land on idle requests
    for (int i = 0; i < 120; i++) begin
      repeat (i % 9) @(negedge clk);
      hostReq(i[0], (i % 17) == 5, 2'(i), 11'(i * 37), 8'(i * 11), 4'(i * 3),
              32'(i) * 32'h0101_0107);
    end
    repeat (2 * RINT) @(negedge clk);
    finish();
  end

endmodule